// File: doc/BRIEF.md
# Toroidal Grid Matrix Multiplier

This block multiplies two square matrices of signed integers on a grid of N by N processing cells. The grid has wraparound links. Each cell keeps one operand from each matrix and one accumulator. One start pulse loads both matrices at the same time, one element into each cell. A short alignment phase then rotates row i of the left matrix by i places and column j of the right matrix by j places. After that the block runs N multiply-accumulate steps. In each step every cell adds the product of its two operands to its accumulator. It then passes its left operand one cell to the left and its right operand one cell up, and both wrap at the grid edges.

Every cell uses only its nearest neighbours. When the sequence ends, the cell at row i, column j holds element (i,j) of the product. The block then raises a one-cycle done pulse. The results stay on the output until the next start. The block is built with N = 4, 8-bit operands and 20-bit accumulators.

Top module: `torus_matmul`

## Requirements
- R1: After reset, busy and done are 0 and every result field of c_flat is 0.
- R2: A start pulse that is sampled while the block is idle does three things at that clock edge: it copies a_flat and b_flat into the cells, clears all accumulators, and drives busy to 1.
- R3: Element (i,j) of each input matrix sits in a_flat and b_flat at bits [(i*N+j)*8 +: 8], with row 0 and column 0 first, as 8-bit two's complement. When done is high, c_flat bits [(i*N+j)*20 +: 20] hold the sum over k of a[i][k]*b[k][j] as 20-bit two's complement.
- R4: Busy stays high for exactly 2N-1 cycles after the start edge: N-1 alignment cycles and N compute cycles. Done is high for exactly one cycle, the first cycle in which busy is low again.
- R5: While busy is high, the start input and any change on a_flat or b_flat have no effect on the result or on the timing of done.
- R6: While the block is idle and start is low, c_flat holds its value, even if the operand inputs change.
- R7: Operands at the extremes of their range (-128 and 127, in every sign combination) give exact sums with no wrap in the accumulator.
- R8: Results are correct for matrices that are not symmetric and for permutation matrices. This shows that the alignment rotates each row and each column by its own amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a multiplication when the block is idle |
| a_flat | input | 128 | Left matrix, element (i,j) at bits [(i*4+j)*8 +: 8] |
| b_flat | input | 128 | Right matrix, same layout as a_flat |
| busy | output | 1 | High while alignment or compute runs |
| done | output | 1 | One-cycle pulse when the results are valid |
| c_flat | output | 320 | Product matrix, element (i,j) at bits [(i*4+j)*20 +: 20] |

## Verification
Permutation and non-symmetric matrices are the main test of the alignment. If a row or column is rotated by the wrong amount, products pair up with the wrong partner, and the error shows up as a transposed or shuffled result. Matrices filled with -128, and matrices that mix -128 and 127, catch a product that is not sign-extended or an accumulator that is too narrow. In both cases the sums wrap or lose their sign. Other tests pulse start and change the operands in the middle of a run, and check c_flat over several idle cycles. These catch a block that restarts, reloads its operands, or keeps changing its outputs after done. Each run also counts the cycles to done, so an extra or a missing alignment or compute step is caught even when the products happen to agree.

// File: rtl/torus_matmul.sv
module torus_matmul #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int CW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*N*DW-1:0] a_flat,
  input  logic [N*N*DW-1:0] b_flat,
  output logic              busy,
  output logic              done,
  output logic [N*N*CW-1:0] c_flat
);
  localparam int SW = $clog2(N) + 1;
  localparam int PW = 2 * DW;

  logic signed [DW-1:0] x [N][N];
  logic signed [DW-1:0] y [N][N];
  logic signed [CW-1:0] acc [N][N];
  logic run, comp, dn;
  logic [SW-1:0] step;

  function automatic logic signed [CW-1:0] mac(
    input logic signed [CW-1:0] s,
    input logic signed [DW-1:0] p,
    input logic signed [DW-1:0] q
  );
    logic signed [PW-1:0] pr;
    pr = PW'(p) * PW'(q);
    return s + CW'(pr);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      comp <= 1'b0;
      dn   <= 1'b0;
      step <= '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          x[i][j]   <= '0;
          y[i][j]   <= '0;
          acc[i][j] <= '0;
        end
    end else begin
      dn <= 1'b0;
      if (!run) begin
        if (start) begin
          run  <= 1'b1;
          comp <= (N == 1);
          step <= '0;
          for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
              x[i][j]   <= a_flat[(i*N+j)*DW +: DW];
              y[i][j]   <= b_flat[(i*N+j)*DW +: DW];
              acc[i][j] <= '0;
            end
        end
      end else if (!comp) begin
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) begin
            if (SW'(i) > step) x[i][j] <= x[i][(j+1)%N];
            if (SW'(j) > step) y[i][j] <= y[(i+1)%N][j];
          end
        if (step == SW'(N-2)) begin
          comp <= 1'b1;
          step <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end else begin
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) begin
            acc[i][j] <= mac(acc[i][j], x[i][j], y[i][j]);
            x[i][j]   <= x[i][(j+1)%N];
            y[i][j]   <= y[(i+1)%N][j];
          end
        if (step == SW'(N-1)) begin
          run  <= 1'b0;
          comp <= 1'b0;
          dn   <= 1'b1;
          step <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  assign busy = run;
  assign done = dn;

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      assign c_flat[(gi*N+gj)*CW +: CW] = acc[gi][gj];
    end
  end
endmodule

// File: rtl/torus_matmul_chk.sv
module torus_matmul_chk #(
  parameter int N  = 4,
  parameter int CW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [N*N*CW-1:0] c_flat
);
  localparam int KW = $clog2(2*N) + 2;
  logic [KW-1:0] busy_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cycles <= '0;
    else if (!busy && start) busy_cycles <= '0;
    else if (busy) busy_cycles <= busy_cycles + 1'b1;
  end

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cycles == KW'(2*N-1)));

  assert_restart_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(c_flat));
endmodule

bind torus_matmul torus_matmul_chk #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .c_flat(c_flat)
);

// File: tb/torus_matmul_test.sv
module torus_matmul_test;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int CW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N*N*DW-1:0] a_flat = '0;
  logic [N*N*DW-1:0] b_flat = '0;
  logic busy, done;
  logic [N*N*CW-1:0] c_flat;

  int tests = 0;
  int fails = 0;
  int am [N][N];
  int bm [N][N];
  int cm [N][N];

  always #10 clk = ~clk;

  torus_matmul #(.N(N), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_flat(a_flat),
    .b_flat(b_flat), .busy(busy), .done(done), .c_flat(c_flat)
  );

  function automatic int cget(int i, int j);
    logic signed [CW-1:0] v;
    v = c_flat[(i*N+j)*CW +: CW];
    return int'(v);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pack_ops();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        a_flat[(i*N+j)*DW +: DW] = DW'(am[i][j]);
        b_flat[(i*N+j)*DW +: DW] = DW'(bm[i][j]);
      end
  endtask

  task automatic ref_mul();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        cm[i][j] = 0;
        for (int k = 0; k < N; k++) cm[i][j] += am[i][k] * bm[k][j];
      end
  endtask

  task automatic check_results(string req);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) check(req, cget(i, j), cm[i][j]);
  endtask

  // run one multiply; disturb=1 pulses start and scrambles operands mid-run (R5)
  task automatic run_mul(string req, bit disturb);
    int cyc;
    pack_ops();
    ref_mul();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", int'(busy), 1);
    check("R2 accumulators cleared", cget(N-1, N-1), 0);
    cyc = 0;
    while (!done && cyc < 100) begin
      if (disturb && cyc == 2) begin
        a_flat = ~a_flat;
        b_flat = b_flat ^ {N*N{8'h5a}};
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check("R4 cycles to done", cyc, 2*N-1);
    check("R4 busy low at done", int'(busy), 0);
    check_results(req);
    @(negedge clk);
    check("R4 done one cycle", int'(done), 0);
  endtask

  task automatic test_reset();
    int nz = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) if (cget(i, j) != 0) nz++;
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 c zero", nz, 0);
  endtask

  task automatic test_permutation();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        am[i][j] = (j == (i + 1) % N) ? 1 : 0;
        bm[i][j] = 10 * i + j + 1;
      end
    run_mul("R8 permutation", 1'b0);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        am[i][j] = i * N + j - 7;
        bm[i][j] = (i == (N - 1 - j)) ? 1 : 0;
      end
    run_mul("R8 anti-diagonal", 1'b0);
  endtask

  task automatic test_nonsym();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        am[i][j] = i * 3 - j * 5 + 2;
        bm[i][j] = j * 7 - i * 2 - 4;
      end
    run_mul("R3 R8 non-symmetric", 1'b0);
  endtask

  task automatic test_extremes();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        am[i][j] = -128;
        bm[i][j] = -128;
      end
    run_mul("R7 all -128", 1'b0);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        am[i][j] = ((i + j) % 2 == 0) ? 127 : -128;
        bm[i][j] = (i % 2 == 0) ? -128 : 127;
      end
    run_mul("R7 mixed extremes", 1'b0);
  endtask

  task automatic test_random();
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          am[i][j] = int'($urandom_range(255)) - 128;
          bm[i][j] = int'($urandom_range(255)) - 128;
        end
      run_mul("R3 random", 1'b0);
    end
  endtask

  task automatic test_busy_ignore();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        am[i][j] = i - 2 * j + 9;
        bm[i][j] = 3 * i + j - 6;
      end
    run_mul("R5 inputs ignored while busy", 1'b1);
  endtask

  task automatic test_hold();
    logic [N*N*CW-1:0] snap;
    snap = c_flat;
    a_flat = ~a_flat;
    b_flat = ~b_flat;
    repeat (6) @(negedge clk);
    check("R6 c held while idle", int'(c_flat == snap), 1);
    check("R6 stays idle", int'(busy), 0);
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_permutation();
    test_nonsym();
    test_extremes();
    test_random();
    test_busy_ignore();
    test_hold();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule